// File: doc/BRIEF.md
# Privilege-Split Tagged Translation Buffer

This block caches virtual-to-physical page translations in a small fully associative table. Every entry is tagged with its virtual page, an address-space identifier built from a virtual-machine field and a process-context field, and a user/kernel mode bit. The user and kernel levels therefore never share entries. Entries can also be marked global. A global entry matches under any address-space identifier, but only in its own mode. A hit returns the physical page and the cache-mode attribute once the requested access has passed a check against the stored rights. An access that fails the check returns a fault instead of a physical address.

On a miss the block holds its lookup port busy and sends a request to an external page-table walker over a valid/ready handshake. It installs the walker's reply, tagged with the identifier and mode of the missing lookup, and then repeats the lookup internally so that it completes as a hit. A normal flush clears every non-global entry. A full flush clears every entry. A single-page invalidation clears the entries for one page and mode. Switching the current identifier never clears anything, so translations from several processes and guests stay resident side by side.

Top module: `tlb_top`

## Requirements
- R1: A lookup is accepted when `lk_valid` is high and `lk_busy` is low. On a hit, `rsp_valid` pulses for exactly one cycle and carries the stored physical page and cache mode. A hit requires a valid entry whose page, mode bit and identifier all equal the request.
- R2: On a miss the block raises `walk_req_valid` carrying the page, the mode and the identifier {vmid, pcid}, with vmid in the upper bits. It holds these stable until `walk_req_ready`. It keeps `lk_busy` high until the reply is installed, then answers as a hit.
- R3: The rights field uses bit0 for read, bit1 for write and bit2 for execute. The access code is 0 for read, 1 for write, 2 for execute and 3 for invalid, and code 3 always faults. If the matching right is clear, the response has `rsp_fault` = 1, with page and cache mode both 0.
- R4: Changing the current identifier removes nothing. A page loaded under two identifiers hits under both afterwards, with no further walk.
- R5: A user-mode access never hits an entry installed in kernel mode, and the reverse also holds. The access causes its own walk.
- R6: A global entry hits under any identifier with the same mode bit. It does not hit in the other mode.
- R7: `flush_cmd` clears all non-global entries and leaves global entries resident. `flush_all` clears every entry.
- R8: `inval_valid` clears every entry whose page and mode equal `inval_vpn` and `inval_user`, global entries included. Other entries stay resident.
- R9: The table holds ENTRIES entries. A fill takes the lowest-numbered free entry if one exists. Otherwise it takes the entry at a round-robin pointer, which advances after each such replacement. With 16 entries filled in order, the 17th fill evicts the first.
- R10: If a flush arrives, or an invalidation of the pending page, while a walk is outstanding, the reply is discarded. The lookup then misses again and issues a fresh walk.
- R11: After reset `lk_busy`, `rsp_valid` and `walk_req_valid` are low and the table is empty, so the first lookup walks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| lk_valid | input | 1 | Lookup request |
| lk_vpn | input | VPN_W | Virtual page of the lookup |
| lk_user | input | 1 | 1 = user mode, 0 = kernel mode |
| lk_acc | input | 2 | Access code: 0 read, 1 write, 2 execute, 3 invalid |
| cur_vmid | input | VMID_W | Current virtual-machine identifier |
| cur_pcid | input | PCID_W | Current process-context identifier |
| lk_busy | output | 1 | Lookup in progress; new requests not taken |
| rsp_valid | output | 1 | One-cycle response strobe |
| rsp_ppn | output | PPN_W | Physical page, 0 on fault |
| rsp_fault | output | 1 | Rights violation |
| rsp_cmode | output | 2 | Cache-mode attribute, 0 on fault |
| flush_cmd | input | 1 | Clear non-global entries |
| flush_all | input | 1 | Clear all entries |
| inval_valid | input | 1 | Single-page invalidation strobe |
| inval_vpn | input | VPN_W | Page to invalidate |
| inval_user | input | 1 | Mode of page to invalidate |
| walk_req_valid | output | 1 | Walk request valid |
| walk_req_ready | input | 1 | Walker accepts request |
| walk_req_vpn | output | VPN_W | Page to walk |
| walk_req_user | output | 1 | Mode of the walk |
| walk_req_asid | output | VMID_W+PCID_W | Identifier {vmid, pcid} |
| walk_rsp_valid | input | 1 | Walker reply strobe |
| walk_rsp_ppn | input | PPN_W | Physical page from walker |
| walk_rsp_rights | input | 3 | Rights {exec, write, read} |
| walk_rsp_cmode | input | 2 | Cache mode from walker |
| walk_rsp_global | input | 1 | Entry is global |

## Verification
The hardest case to reach is a flush that lands while a walk is in flight. The window for it is only as long as the walker's reply latency. The bench walker therefore uses a configurable reply delay and counts accepted walks. A parallel thread waits for that count to move, then pulses the flush inside the delay. The test passes only if a second walk follows. Replacement is reached by loading exactly the table's capacity of distinct pages, then adding one more. Probes then show which page was evicted.

// File: rtl/tlb_pkg.sv
package tlb_pkg;

  typedef enum logic [1:0] {
    ACC_READ  = 2'd0,
    ACC_WRITE = 2'd1,
    ACC_EXEC  = 2'd2,
    ACC_BAD   = 2'd3
  } acc_e;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_LOOK,
    ST_WREQ,
    ST_WAIT
  } tlb_state_e;

  localparam int RIGHTS_W = 3;
  localparam int CMODE_W  = 2;

endpackage

// File: rtl/tlb_array.sv
module tlb_array
  import tlb_pkg::*;
#(
  parameter int ENTRIES = 16,
  parameter int VPN_W   = 20,
  parameter int PPN_W   = 20,
  parameter int ASID_W  = 12,
  parameter int IDX_W   = $clog2(ENTRIES)
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [VPN_W-1:0]    cmp_vpn,
  input  logic                cmp_user,
  input  logic [ASID_W-1:0]   cmp_asid,
  output logic                hit,
  output logic [PPN_W-1:0]    hit_ppn,
  output logic [RIGHTS_W-1:0] hit_rights,
  output logic [CMODE_W-1:0]  hit_cmode,
  output logic [ENTRIES-1:0]  valid_vec,
  input  logic                wr_en,
  input  logic [IDX_W-1:0]    wr_idx,
  input  logic [VPN_W-1:0]    wr_vpn,
  input  logic                wr_user,
  input  logic [ASID_W-1:0]   wr_asid,
  input  logic                wr_glob,
  input  logic [PPN_W-1:0]    wr_ppn,
  input  logic [RIGHTS_W-1:0] wr_rights,
  input  logic [CMODE_W-1:0]  wr_cmode,
  input  logic                fl_local,
  input  logic                fl_all,
  input  logic                inv_en,
  input  logic [VPN_W-1:0]    inv_vpn,
  input  logic                inv_user
);

  logic [ENTRIES-1:0]  e_val;
  logic [ENTRIES-1:0]  e_glob;
  logic [ENTRIES-1:0]  e_user;
  logic [VPN_W-1:0]    e_vpn    [ENTRIES];
  logic [ASID_W-1:0]   e_asid   [ENTRIES];
  logic [PPN_W-1:0]    e_ppn    [ENTRIES];
  logic [RIGHTS_W-1:0] e_rights [ENTRIES];
  logic [CMODE_W-1:0]  e_cmode  [ENTRIES];

  logic [ENTRIES-1:0]  match;
  logic [ENTRIES-1:0]  inv_hit;

  // Per-entry tag comparators
  for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
    assign match[g] = e_val[g] && (e_vpn[g] == cmp_vpn) && (e_user[g] == cmp_user) &&
                      (e_glob[g] || (e_asid[g] == cmp_asid));
    assign inv_hit[g] = (e_vpn[g] == inv_vpn) && (e_user[g] == inv_user);
  end

  // Valid bits: flush and invalidation dominate a write
  always_ff @(posedge clk) begin
    if (rst) begin
      e_val <= '0;
    end else begin
      for (int i = 0; i < ENTRIES; i++) begin
        if (fl_all)
          e_val[i] <= 1'b0;
        else if (fl_local && !e_glob[i])
          e_val[i] <= 1'b0;
        else if (inv_en && inv_hit[i])
          e_val[i] <= 1'b0;
        else if (wr_en && (wr_idx == IDX_W'(i)))
          e_val[i] <= 1'b1;
      end
    end
  end

  // Payload storage, no reset needed
  always_ff @(posedge clk) begin
    if (wr_en) begin
      e_vpn[wr_idx]    <= wr_vpn;
      e_asid[wr_idx]   <= wr_asid;
      e_ppn[wr_idx]    <= wr_ppn;
      e_rights[wr_idx] <= wr_rights;
      e_cmode[wr_idx]  <= wr_cmode;
      e_glob[wr_idx]   <= wr_glob;
      e_user[wr_idx]   <= wr_user;
    end
  end

  // One-hot mux of the matching entry
  always_comb begin
    hit        = |match;
    hit_ppn    = '0;
    hit_rights = '0;
    hit_cmode  = '0;
    for (int i = 0; i < ENTRIES; i++) begin
      hit_ppn    = hit_ppn    | ({PPN_W{match[i]}} & e_ppn[i]);
      hit_rights = hit_rights | ({RIGHTS_W{match[i]}} & e_rights[i]);
      hit_cmode  = hit_cmode  | ({CMODE_W{match[i]}} & e_cmode[i]);
    end
  end

  assign valid_vec = e_val;

endmodule

// File: rtl/tlb_victim.sv
module tlb_victim #(
  parameter int ENTRIES = 16,
  parameter int IDX_W   = $clog2(ENTRIES)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [ENTRIES-1:0] valid_vec,
  input  logic               adv,
  output logic [IDX_W-1:0]   idx
);

  logic [IDX_W-1:0] rr;
  logic [IDX_W-1:0] free_idx;
  logic             any_free;

  // Lowest-numbered free slot wins
  always_comb begin
    any_free = 1'b0;
    free_idx = '0;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (!valid_vec[i]) begin
        any_free = 1'b1;
        free_idx = IDX_W'(i);
      end
    end
    idx = any_free ? free_idx : rr;
  end

  always_ff @(posedge clk) begin
    if (rst)
      rr <= '0;
    else if (adv && !any_free)
      rr <= (rr == IDX_W'(ENTRIES - 1)) ? '0 : rr + 1'b1;
  end

endmodule

// File: rtl/tlb_top.sv
module tlb_top
  import tlb_pkg::*;
#(
  parameter int VPN_W   = 20,
  parameter int PPN_W   = 20,
  parameter int VMID_W  = 4,
  parameter int PCID_W  = 8,
  parameter int ENTRIES = 16
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      lk_valid,
  input  logic [VPN_W-1:0]          lk_vpn,
  input  logic                      lk_user,
  input  logic [1:0]                lk_acc,
  input  logic [VMID_W-1:0]         cur_vmid,
  input  logic [PCID_W-1:0]         cur_pcid,
  output logic                      lk_busy,
  output logic                      rsp_valid,
  output logic [PPN_W-1:0]          rsp_ppn,
  output logic                      rsp_fault,
  output logic [1:0]                rsp_cmode,
  input  logic                      flush_cmd,
  input  logic                      flush_all,
  input  logic                      inval_valid,
  input  logic [VPN_W-1:0]          inval_vpn,
  input  logic                      inval_user,
  output logic                      walk_req_valid,
  input  logic                      walk_req_ready,
  output logic [VPN_W-1:0]          walk_req_vpn,
  output logic                      walk_req_user,
  output logic [VMID_W+PCID_W-1:0]  walk_req_asid,
  input  logic                      walk_rsp_valid,
  input  logic [PPN_W-1:0]          walk_rsp_ppn,
  input  logic [2:0]                walk_rsp_rights,
  input  logic [1:0]                walk_rsp_cmode,
  input  logic                      walk_rsp_global
);

  localparam int ASID_W = VMID_W + PCID_W;
  localparam int IDX_W  = $clog2(ENTRIES);

  tlb_state_e          st;
  logic [VPN_W-1:0]    q_vpn;
  logic                q_user;
  acc_e                q_acc;
  logic [ASID_W-1:0]   q_asid;
  logic                stale;

  logic                hit;
  logic [PPN_W-1:0]    hit_ppn;
  logic [RIGHTS_W-1:0] hit_rights;
  logic [CMODE_W-1:0]  hit_cmode;
  logic [ENTRIES-1:0]  valid_vec;
  logic [IDX_W-1:0]    vic_idx;
  logic                wr_en;
  logic                any_fl;
  logic                kill;
  logic                allowed;

  assign any_fl  = flush_cmd | flush_all | inval_valid;
  assign kill    = flush_cmd | flush_all |
                   (inval_valid && (inval_vpn == q_vpn) && (inval_user == q_user));
  assign wr_en   = (st == ST_WAIT) && walk_rsp_valid && !stale && !any_fl;
  assign allowed = (q_acc != ACC_BAD) && hit_rights[q_acc];

  tlb_array #(
    .ENTRIES(ENTRIES), .VPN_W(VPN_W), .PPN_W(PPN_W), .ASID_W(ASID_W), .IDX_W(IDX_W)
  ) u_array (
    .clk        (clk),
    .rst        (rst),
    .cmp_vpn    (q_vpn),
    .cmp_user   (q_user),
    .cmp_asid   (q_asid),
    .hit        (hit),
    .hit_ppn    (hit_ppn),
    .hit_rights (hit_rights),
    .hit_cmode  (hit_cmode),
    .valid_vec  (valid_vec),
    .wr_en      (wr_en),
    .wr_idx     (vic_idx),
    .wr_vpn     (q_vpn),
    .wr_user    (q_user),
    .wr_asid    (q_asid),
    .wr_glob    (walk_rsp_global),
    .wr_ppn     (walk_rsp_ppn),
    .wr_rights  (walk_rsp_rights),
    .wr_cmode   (walk_rsp_cmode),
    .fl_local   (flush_cmd),
    .fl_all     (flush_all),
    .inv_en     (inval_valid),
    .inv_vpn    (inval_vpn),
    .inv_user   (inval_user)
  );

  tlb_victim #(.ENTRIES(ENTRIES), .IDX_W(IDX_W)) u_victim (
    .clk       (clk),
    .rst       (rst),
    .valid_vec (valid_vec),
    .adv       (wr_en),
    .idx       (vic_idx)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      st             <= ST_IDLE;
      q_vpn          <= '0;
      q_user         <= 1'b0;
      q_acc          <= ACC_READ;
      q_asid         <= '0;
      stale          <= 1'b0;
      rsp_valid      <= 1'b0;
      rsp_ppn        <= '0;
      rsp_fault      <= 1'b0;
      rsp_cmode      <= '0;
      walk_req_valid <= 1'b0;
    end else begin
      rsp_valid <= 1'b0;
      unique case (st)
        ST_IDLE: begin
          if (lk_valid) begin
            q_vpn  <= lk_vpn;
            q_user <= lk_user;
            q_acc  <= acc_e'(lk_acc);
            q_asid <= {cur_vmid, cur_pcid};
            st     <= ST_LOOK;
          end
        end
        ST_LOOK: begin
          // A maintenance command this cycle forces a fresh compare
          if (!any_fl) begin
            if (hit) begin
              rsp_valid <= 1'b1;
              rsp_fault <= !allowed;
              rsp_ppn   <= allowed ? hit_ppn : '0;
              rsp_cmode <= allowed ? hit_cmode : '0;
              st        <= ST_IDLE;
            end else begin
              walk_req_valid <= 1'b1;
              stale          <= 1'b0;
              st             <= ST_WREQ;
            end
          end
        end
        ST_WREQ: begin
          if (kill) stale <= 1'b1;
          if (walk_req_ready) begin
            walk_req_valid <= 1'b0;
            st             <= ST_WAIT;
          end
        end
        ST_WAIT: begin
          if (kill) stale <= 1'b1;
          if (walk_rsp_valid) st <= ST_LOOK;
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  assign lk_busy       = (st != ST_IDLE);
  assign walk_req_vpn  = q_vpn;
  assign walk_req_user = q_user;
  assign walk_req_asid = q_asid;

endmodule

// File: rtl/tlb_top_chk.sv
module tlb_top_chk #(
  parameter int VPN_W  = 20,
  parameter int PPN_W  = 20,
  parameter int ASID_W = 12
) (
  input logic              clk,
  input logic              rst,
  input logic              lk_busy,
  input logic              rsp_valid,
  input logic              rsp_fault,
  input logic [PPN_W-1:0]  rsp_ppn,
  input logic [1:0]        rsp_cmode,
  input logic              walk_req_valid,
  input logic              walk_req_ready,
  input logic [VPN_W-1:0]  walk_req_vpn,
  input logic [ASID_W-1:0] walk_req_asid
);

  AST_RSP_SINGLE: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |=> !rsp_valid); // R1

  AST_RSP_FREES_PORT: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |-> !lk_busy); // R1

  AST_WALK_HELD: assert property (@(posedge clk) disable iff (rst)
    (walk_req_valid && !walk_req_ready) |=>
      (walk_req_valid && $stable(walk_req_vpn) && $stable(walk_req_asid))); // R2

  AST_WALK_WHILE_BUSY: assert property (@(posedge clk) disable iff (rst)
    walk_req_valid |-> lk_busy); // R2

  AST_FAULT_NO_ADDR: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && rsp_fault) |-> (rsp_ppn == '0 && rsp_cmode == 2'd0)); // R3

endmodule

bind tlb_top tlb_top_chk #(
  .VPN_W(VPN_W), .PPN_W(PPN_W), .ASID_W(VMID_W + PCID_W)
) u_chk (
  .clk            (clk),
  .rst            (rst),
  .lk_busy        (lk_busy),
  .rsp_valid      (rsp_valid),
  .rsp_fault      (rsp_fault),
  .rsp_ppn        (rsp_ppn),
  .rsp_cmode      (rsp_cmode),
  .walk_req_valid (walk_req_valid),
  .walk_req_ready (walk_req_ready),
  .walk_req_vpn   (walk_req_vpn),
  .walk_req_asid  (walk_req_asid)
);

// File: tb/tlb_top_test.sv
`timescale 1ns/1ps
module tlb_top_test;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        lk_valid = 1'b0;
  logic [19:0] lk_vpn = '0;
  logic        lk_user = 1'b0;
  logic [1:0]  lk_acc = '0;
  logic [3:0]  cur_vmid = '0;
  logic [7:0]  cur_pcid = '0;
  logic        lk_busy, rsp_valid, rsp_fault;
  logic [19:0] rsp_ppn;
  logic [1:0]  rsp_cmode;
  logic        flush_cmd = 1'b0, flush_all = 1'b0, inval_valid = 1'b0;
  logic [19:0] inval_vpn = '0;
  logic        inval_user = 1'b0;
  logic        walk_req_valid, walk_req_user;
  logic        walk_req_ready = 1'b0;
  logic [19:0] walk_req_vpn;
  logic [11:0] walk_req_asid;
  logic        walk_rsp_valid = 1'b0;
  logic [19:0] walk_rsp_ppn = '0;
  logic [2:0]  walk_rsp_rights = '0;
  logic [1:0]  walk_rsp_cmode = '0;
  logic        walk_rsp_global = 1'b0;

  int checks = 0;
  int errs = 0;
  int walks = 0;
  int wk_delay = 2;
  logic [19:0] cap_vpn;
  logic        cap_user;
  logic [11:0] cap_asid;
  logic [19:0] got_ppn;
  logic        got_fault;
  logic [1:0]  got_cmode;

  always #4 clk = ~clk;

  tlb_top uut (
    .clk(clk), .rst(rst), .lk_valid(lk_valid), .lk_vpn(lk_vpn), .lk_user(lk_user),
    .lk_acc(lk_acc), .cur_vmid(cur_vmid), .cur_pcid(cur_pcid), .lk_busy(lk_busy),
    .rsp_valid(rsp_valid), .rsp_ppn(rsp_ppn), .rsp_fault(rsp_fault), .rsp_cmode(rsp_cmode),
    .flush_cmd(flush_cmd), .flush_all(flush_all), .inval_valid(inval_valid),
    .inval_vpn(inval_vpn), .inval_user(inval_user), .walk_req_valid(walk_req_valid),
    .walk_req_ready(walk_req_ready), .walk_req_vpn(walk_req_vpn), .walk_req_user(walk_req_user),
    .walk_req_asid(walk_req_asid), .walk_rsp_valid(walk_rsp_valid), .walk_rsp_ppn(walk_rsp_ppn),
    .walk_rsp_rights(walk_rsp_rights), .walk_rsp_cmode(walk_rsp_cmode),
    .walk_rsp_global(walk_rsp_global)
  );

  // Page-table model
  function automatic bit is_glob(input logic [19:0] v);
    return v[3:0] == 4'hF;
  endfunction

  function automatic logic [19:0] pt_ppn(input logic [19:0] v, input logic u, input logic [11:0] a);
    logic [19:0] p;
    p = v * 20'd7 + (u ? 20'h30000 : 20'h0);
    if (!is_glob(v)) p = p + 20'(a) * 20'h101;
    return p;
  endfunction

  function automatic logic [22:0] exp_rsp(input logic [19:0] v, input logic u,
                                          input logic [1:0] acc, input logic [11:0] a);
    logic [2:0] r;
    r = v[6:4];
    if (acc == 2'd3 || !r[acc]) return {1'b1, 2'b00, 20'h0};
    return {1'b0, v[1:0], pt_ppn(v, u, a)};
  endfunction

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Walker: ready one cycle, reply after wk_delay cycles
  bit pend = 0;
  int cnt = 0;
  always @(negedge clk) begin
    if (rst) begin
      walk_req_ready = 0; walk_rsp_valid = 0; pend = 0;
    end else begin
      walk_rsp_valid = 0;
      if (walk_req_ready) begin
        walk_req_ready = 0; walks++; pend = 1; cnt = wk_delay;
      end else if (walk_req_valid && !pend) begin
        walk_req_ready = 1;
        cap_vpn = walk_req_vpn; cap_user = walk_req_user; cap_asid = walk_req_asid;
      end
      if (pend) begin
        if (cnt == 0) begin
          pend = 0;
          walk_rsp_valid  = 1;
          walk_rsp_ppn    = pt_ppn(cap_vpn, cap_user, cap_asid);
          walk_rsp_rights = cap_vpn[6:4];
          walk_rsp_cmode  = cap_vpn[1:0];
          walk_rsp_global = is_glob(cap_vpn);
        end else cnt--;
      end
    end
  end

  task automatic look(input logic [19:0] v, input logic u, input logic [1:0] acc,
                      input logic [3:0] vm, input logic [7:0] pc, input string req);
    int n;
    logic [22:0] e;
    @(negedge clk);
    while (lk_busy) @(negedge clk);
    lk_valid = 1; lk_vpn = v; lk_user = u; lk_acc = acc; cur_vmid = vm; cur_pcid = pc;
    @(negedge clk);
    lk_valid = 0;
    n = 0;
    while (!rsp_valid && n < 300) begin @(negedge clk); n++; end
    got_ppn = rsp_ppn; got_fault = rsp_fault; got_cmode = rsp_cmode;
    e = exp_rsp(v, u, acc, {vm, pc});
    chk(rsp_valid && {got_fault, got_cmode, got_ppn} == e, req,
        64'({got_fault, got_cmode, got_ppn}), 64'(e));
  endtask

  task automatic look_walks(input logic [19:0] v, input logic u, input logic [3:0] vm,
                            input logic [7:0] pc, input int dw, input string req);
    int w0;
    w0 = walks;
    look(v, u, 2'd0, vm, pc, req);
    chk(walks == w0 + dw, req, 64'(walks - w0), 64'(dw));
  endtask

  task automatic maint(input int kind, input logic [19:0] v, input logic u);
    @(negedge clk);
    while (lk_busy) @(negedge clk);
    case (kind)
      0: flush_cmd = 1;
      1: flush_all = 1;
      default: begin inval_valid = 1; inval_vpn = v; inval_user = u; end
    endcase
    @(negedge clk);
    flush_cmd = 0; flush_all = 0; inval_valid = 0;
  endtask

  initial begin
    #(8 * 150000);
    checks++; errs++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    int w0;
    process_seed();
    repeat (4) @(negedge clk);
    rst = 0;
    @(negedge clk);
    // R11 reset state
    chk(!lk_busy, "R11 busy", 64'(lk_busy), 0);
    chk(!rsp_valid, "R11 rsp", 64'(rsp_valid), 0);
    chk(!walk_req_valid, "R11 walk", 64'(walk_req_valid), 0);
    look_walks(20'h00123, 0, 4'h1, 8'h22, 1, "R11 first lookup walks");
    // R2 request fields
    chk(cap_vpn == 20'h00123 && cap_user == 0 && cap_asid == 12'h122, "R2 walk fields",
        64'({cap_vpn, cap_user, cap_asid}), 64'({20'h00123, 1'b0, 12'h122}));
    // R1 hit
    look_walks(20'h00123, 0, 4'h1, 8'h22, 0, "R1 hit");
    // R3 rights: vpn 0x010 has read only
    look_walks(20'h00010, 0, 4'h1, 8'h22, 1, "R3 read ok");
    look(20'h00010, 0, 2'd1, 4'h1, 8'h22, "R3 write faults");
    look(20'h00010, 0, 2'd2, 4'h1, 8'h22, "R3 exec faults");
    look(20'h00010, 0, 2'd3, 4'h1, 8'h22, "R3 bad code faults");
    look(20'h00070, 0, 2'd2, 4'h1, 8'h22, "R3 exec allowed");
    // R4 identifiers coexist
    look_walks(20'h00300, 0, 4'h2, 8'h05, 1, "R4 asid A walk");
    look_walks(20'h00300, 0, 4'h3, 8'h05, 1, "R4 asid B walk");
    look_walks(20'h00300, 0, 4'h2, 8'h05, 0, "R4 asid A resident");
    look_walks(20'h00300, 0, 4'h3, 8'h05, 0, "R4 asid B resident");
    // R5 mode separation
    look_walks(20'h00300, 1, 4'h2, 8'h05, 1, "R5 user misses kernel entry");
    look_walks(20'h00300, 1, 4'h2, 8'h05, 0, "R5 user entry hit");
    // R6 global
    look_walks(20'h0004F, 0, 4'h1, 8'h01, 1, "R6 global fill");
    look_walks(20'h0004F, 0, 4'h7, 8'h99, 0, "R6 global any asid");
    look_walks(20'h0004F, 1, 4'h7, 8'h99, 1, "R6 global other mode");
    // R7 normal flush
    maint(0, 0, 0);
    look_walks(20'h00300, 0, 4'h2, 8'h05, 1, "R7 flush clears local");
    look_walks(20'h0004F, 0, 4'h5, 8'h05, 0, "R7 global survives");
    // R8 invalidation
    maint(2, 20'h0004F, 0);
    look_walks(20'h0004F, 1, 4'h5, 8'h05, 0, "R8 other mode stays");
    look_walks(20'h00300, 0, 4'h2, 8'h05, 0, "R8 other page stays");
    look_walks(20'h0004F, 0, 4'h5, 8'h05, 1, "R8 global page removed");
    // R7 full flush
    maint(1, 0, 0);
    look_walks(20'h0004F, 1, 4'h5, 8'h05, 1, "R7 full flush clears global");
    // R9 replacement
    maint(1, 0, 0);
    for (int i = 0; i < 16; i++) look(20'h00200 + 20'(i), 0, 2'd0, 4'h1, 8'h01, "R9 fill");
    look_walks(20'h00210, 0, 4'h1, 8'h01, 1, "R9 17th walks");
    look_walks(20'h00202, 0, 4'h1, 8'h01, 0, "R9 third kept");
    look_walks(20'h00200, 0, 4'h1, 8'h01, 1, "R9 first evicted");
    // R10 flush during walk
    wk_delay = 6;
    w0 = walks;
    fork
      look(20'h00555, 0, 2'd0, 4'h1, 8'h01, "R10 result");
      begin
        wait (walks == w0 + 1);
        @(negedge clk); flush_cmd = 1;
        @(negedge clk); flush_cmd = 0;
      end
    join
    chk(walks == w0 + 2, "R10 rewalk after flush", 64'(walks - w0), 2);
    wk_delay = 2;
    // Random traffic
    for (int k = 0; k < 300; k++) begin
      logic [19:0] v;
      v = 20'h00400 + 20'($urandom_range(0, 127));
      if ($urandom_range(0, 19) == 0) maint($urandom_range(0, 2), v, 1'($urandom_range(0, 1)));
      wk_delay = $urandom_range(0, 4);
      look(v, 1'($urandom_range(0, 1)), 2'($urandom_range(0, 3)),
           4'($urandom_range(0, 2)), 8'h10, "R1 random translation");
    end
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  task automatic process_seed();
    int unsigned s;
    s = $urandom(32'd1234);
  endtask

endmodule